// File: doc/BRIEF.md
# Multiplexed GPIO Port Register Block

This block holds the pin configuration for several GPIO ports of 32 pins each and exposes it over a simple 32-bit register bus. For every pin it stores a 3-bit function selector, an output data bit, a 2-bit drive-strength code and a 2-bit pull code. Each port also has a 4-bit I/O bias field. All stored fields drive the pad ring directly. Pad input levels pass through a two-flop synchronizer and can be read back through the data register.

Every port occupies a 0x24-byte window, so the ports do not sit on power-of-two boundaries. Function selectors are packed eight pins per word, one nibble per pin. Drive and pull codes are packed sixteen pins per word. The bias words form a separate array starting at 0x300. Software issues a request with a write strobe. A write updates the addressed field at the clock edge. A read returns data one cycle after the request.

Top module: `pinmux_gpio_regs`

## Requirements
- R1: Reset clears every stored field to zero, so every pin starts as an input with no pull, no output enable, drive code 0 and bias 0. `rdata_o` also resets to 0.
- R2: The function words sit at port offsets 0x00, 0x04, 0x08 and 0x0C. Pin p uses word p/8, bits 4*(p%8)+2 down to 4*(p%8). Bit 3 of every nibble is not stored and reads 0. The stored code appears on `pad_func_o`, bits 3*g+2:3*g, where g = 32*port + pin.
- R3: `pad_oe_o[g]` is 1 exactly when the function code of pin g is 1, which selects GPIO output. Code 0 selects GPIO input, and codes 2 to 7 select alternate functions. `pad_out_o[g]` is bit (g%32) of that port's data register.
- R4: A read of the data register at port offset 0x10 returns, for each pin, the stored output bit if the pin's function code is 1. Otherwise it returns the pad level synchronized through two flops. A pad change is visible in a read issued three cycles later.
- R5: The drive words sit at port offsets 0x14 (pins 0 to 15) and 0x18 (pins 16 to 31), at bits 2*(p%16)+1:2*(p%16). The code is level/10-1, so levels 10, 20, 30 and 40 map to codes 0, 1, 2 and 3. The code is driven on `pad_drv_o` at bits 2*g+1:2*g.
- R6: The pull words sit at port offsets 0x1C (pins 0 to 15) and 0x20 (pins 16 to 31), with the same bit packing as R5. Code 0 means no pull, 1 means pull-up and 2 means pull-down. The code is driven on `pad_pull_o` at bits 2*g+1:2*g.
- R7: The bias word of port n is at 0x300+4*n. Only bits 3:0 are stored, and they are driven on `pad_bias_o` at bits 4*n+3:4*n. Bits 31:4 read 0.
- R8: The registers of port n start at byte address 0x24*n. A write to one port leaves the fields of every other port unchanged.
- R9: A write to an address outside the map is ignored, and a read from such an address returns 0. Outside the map means an address that is not word aligned, a port window beyond the last port, or a bias word of a port that does not exist.
- R10: A read request at one clock edge updates `rdata_o` at that edge. `rdata_o` holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| pad_in_i | input | NP*32 | Asynchronous pad input levels |
| pad_out_o | output | NP*32 | Pad output values |
| pad_oe_o | output | NP*32 | Pad output enables |
| pad_func_o | output | NP*96 | Function code per pin, 3 bits each |
| pad_drv_o | output | NP*64 | Drive code per pin, 2 bits each |
| pad_pull_o | output | NP*64 | Pull code per pin, 2 bits each |
| pad_bias_o | output | NP*4 | I/O bias code per port |

## Verification
The bench targets the packing boundaries. It writes pin 25 in the last function word and pin 20 in the upper drive word. A decoder that mixed up densities would light the wrong pad field, or the wrong nibble would read back. It writes all ones to function and bias words. A design that stored nibble bit 3 or the upper bias bits would return them on read. It uses port 1 and port 2 addresses to check the 0x24 stride, and it reads the data register with inputs and outputs mixed. A design that returned the pad level for output pins would lose the stored 1 on pin 25. Finally, it writes one address past the last port, a bias word of a port that does not exist, a misaligned address inside a port and an address in the gap before the bias array. A loose decoder would alias one of these into a real field.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int unsigned PINS     = 32;
  localparam int unsigned FUNC_W   = 3;
  localparam int unsigned DRV_W    = 2;
  localparam int unsigned PULL_W   = 2;
  localparam int unsigned BIAS_W   = 4;
  localparam int unsigned STRIDE   = 36;   // 0x24 bytes per port
  localparam int unsigned GRP_BASE = 768;  // 0x300
  localparam logic [FUNC_W-1:0] FN_IN  = 3'd0;
  localparam logic [FUNC_W-1:0] FN_OUT = 3'd1;

  typedef enum logic [2:0] {
    K_NONE, K_FUNC, K_DATA, K_DRV, K_PULL, K_GRP
  } reg_kind_e;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pinmux_port_dec.sv
module pinmux_port_dec
  import pinmux_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned PORT_IDX = 0
) (
  input  logic [AW-1:0] addr_i,
  output reg_kind_e     kind_o,
  output logic [1:0]    idx_o
);
  localparam logic [AW-1:0] BASE = AW'(PORT_IDX * STRIDE);
  localparam logic [AW-1:0] GRP  = AW'(GRP_BASE + 4 * PORT_IDX);

  logic [AW-1:0] off;

  always_comb begin
    off    = addr_i - BASE;
    kind_o = K_NONE;
    idx_o  = 2'd0;
    if (addr_i == GRP) begin
      kind_o = K_GRP;
    end else if (addr_i >= BASE) begin
      case (off)
        AW'(0):  begin kind_o = K_FUNC; idx_o = 2'd0; end
        AW'(4):  begin kind_o = K_FUNC; idx_o = 2'd1; end
        AW'(8):  begin kind_o = K_FUNC; idx_o = 2'd2; end
        AW'(12): begin kind_o = K_FUNC; idx_o = 2'd3; end
        AW'(16): kind_o = K_DATA;
        AW'(20): begin kind_o = K_DRV;  idx_o = 2'd0; end
        AW'(24): begin kind_o = K_DRV;  idx_o = 2'd1; end
        AW'(28): begin kind_o = K_PULL; idx_o = 2'd0; end
        AW'(32): begin kind_o = K_PULL; idx_o = 2'd1; end
        default: kind_o = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  reg_kind_e                kind_i,
  input  logic [1:0]               idx_i,
  input  logic [31:0]              wdata_i,
  input  logic [PINS-1:0]          pad_in_i,
  output logic [31:0]              rdata_o,
  output logic [PINS-1:0]          out_o,
  output logic [PINS-1:0]          oe_o,
  output logic [PINS*FUNC_W-1:0]   func_o,
  output logic [PINS*DRV_W-1:0]    drv_o,
  output logic [PINS*PULL_W-1:0]   pull_o,
  output logic [BIAS_W-1:0]        bias_o
);
  logic [PINS-1:0][FUNC_W-1:0] func_q;
  logic [PINS-1:0][DRV_W-1:0]  drv_q;
  logic [PINS-1:0][PULL_W-1:0] pull_q;
  logic [PINS-1:0]             dout_q;
  logic [BIAS_W-1:0]           bias_q;
  logic [PINS-1:0]             pin_sync;

  pinmux_sync #(.W(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      func_q <= '0;
      drv_q  <= '0;
      pull_q <= '0;
      dout_q <= '0;
      bias_q <= '0;
    end else if (wr_i) begin
      case (kind_i)
        K_FUNC: for (int j = 0; j < 8; j++)
                  func_q[{idx_i, 3'(j)}] <= wdata_i[4*j +: FUNC_W];
        K_DATA: dout_q <= wdata_i;
        K_DRV:  for (int j = 0; j < 16; j++)
                  drv_q[{idx_i[0], 4'(j)}] <= wdata_i[2*j +: DRV_W];
        K_PULL: for (int j = 0; j < 16; j++)
                  pull_q[{idx_i[0], 4'(j)}] <= wdata_i[2*j +: PULL_W];
        K_GRP:  bias_q <= wdata_i[BIAS_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (kind_i)
      K_FUNC: for (int j = 0; j < 8; j++)
                rdata_o[4*j +: FUNC_W] = func_q[{idx_i, 3'(j)}];
      K_DATA: for (int p = 0; p < PINS; p++)
                rdata_o[p] = (func_q[p] == FN_OUT) ? dout_q[p] : pin_sync[p];
      K_DRV:  for (int j = 0; j < 16; j++)
                rdata_o[2*j +: DRV_W] = drv_q[{idx_i[0], 4'(j)}];
      K_PULL: for (int j = 0; j < 16; j++)
                rdata_o[2*j +: PULL_W] = pull_q[{idx_i[0], 4'(j)}];
      K_GRP:  rdata_o[BIAS_W-1:0] = bias_q;
      default: ;
    endcase
  end

  always_comb begin
    for (int p = 0; p < PINS; p++) oe_o[p] = (func_q[p] == FN_OUT);
  end

  assign out_o  = dout_q;
  assign func_o = func_q;
  assign drv_o  = drv_q;
  assign pull_o = pull_q;
  assign bias_o = bias_q;
endmodule

// File: rtl/pinmux_gpio_regs.sv
module pinmux_gpio_regs
  import pinmux_pkg::*;
#(
  parameter int unsigned NP = 3,
  parameter int unsigned AW = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  input  logic [NP*PINS-1:0]       pad_in_i,
  output logic [NP*PINS-1:0]       pad_out_o,
  output logic [NP*PINS-1:0]       pad_oe_o,
  output logic [NP*PINS*FUNC_W-1:0] pad_func_o,
  output logic [NP*PINS*DRV_W-1:0] pad_drv_o,
  output logic [NP*PINS*PULL_W-1:0] pad_pull_o,
  output logic [NP*BIAS_W-1:0]     pad_bias_o
);
  logic [NP-1:0][31:0] port_rd;
  logic [31:0]         rd_any;
  logic                wr;

  assign wr = req_i & we_i;

  for (genvar p = 0; p < NP; p++) begin : g_port
    reg_kind_e  kind;
    logic [1:0] idx;

    pinmux_port_dec #(.AW(AW), .PORT_IDX(p)) u_dec (
      .addr_i (addr_i),
      .kind_o (kind),
      .idx_o  (idx)
    );

    pinmux_port u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr),
      .kind_i   (kind),
      .idx_i    (idx),
      .wdata_i  (wdata_i),
      .pad_in_i (pad_in_i[p*PINS +: PINS]),
      .rdata_o  (port_rd[p]),
      .out_o    (pad_out_o[p*PINS +: PINS]),
      .oe_o     (pad_oe_o[p*PINS +: PINS]),
      .func_o   (pad_func_o[p*PINS*FUNC_W +: PINS*FUNC_W]),
      .drv_o    (pad_drv_o[p*PINS*DRV_W +: PINS*DRV_W]),
      .pull_o   (pad_pull_o[p*PINS*PULL_W +: PINS*PULL_W]),
      .bias_o   (pad_bias_o[p*BIAS_W +: BIAS_W])
    );
  end

  // at most one port decodes a given address
  always_comb begin
    rd_any = '0;
    for (int p = 0; p < NP; p++) rd_any = rd_any | port_rd[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_any;
  end
endmodule

// File: rtl/pinmux_gpio_regs_chk.sv
module pinmux_gpio_regs_chk #(
  parameter int unsigned NP = 3,
  parameter int unsigned AW = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [AW-1:0]       addr_i,
  input logic [31:0]         rdata_o,
  input logic [NP*32-1:0]    pad_out_o,
  input logic [NP*32-1:0]    pad_oe_o,
  input logic [NP*96-1:0]    pad_func_o,
  input logic [NP*64-1:0]    pad_drv_o,
  input logic [NP*64-1:0]    pad_pull_o,
  input logic [NP*4-1:0]     pad_bias_o
);
  logic mapped, func_rd_win, grp_hit;

  always_comb begin
    mapped      = 1'b0;
    func_rd_win = 1'b0;
    grp_hit     = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (int'(addr_i) == 768 + 4 * p) begin
        mapped  = 1'b1;
        grp_hit = 1'b1;
      end
      if (addr_i[1:0] == 2'b00 && int'(addr_i) >= 36 * p && int'(addr_i) < 36 * p + 36)
        mapped = 1'b1;
      if (addr_i[1:0] == 2'b00 && int'(addr_i) >= 36 * p && int'(addr_i) < 36 * p + 16)
        func_rd_win = 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0 && pad_pull_o == '0 && pad_func_o == '0 && rdata_o == '0));

  p_func_nibble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && func_rd_win) |=> ((rdata_o & 32'h8888_8888) == 32'h0));

  p_fields_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(pad_func_o) && $stable(pad_drv_o) &&
                          $stable(pad_pull_o) && $stable(pad_bias_o) && $stable(pad_out_o)));

  p_bias_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && grp_hit) |=> (rdata_o[31:4] == 28'h0));

  p_unmapped_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !mapped) |=> ($stable(pad_func_o) && $stable(pad_drv_o) &&
                                    $stable(pad_pull_o) && $stable(pad_bias_o) && $stable(pad_out_o)));

  p_unmapped_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> (rdata_o == 32'h0));

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  for (genvar g = 0; g < NP * 32; g++) begin : g_oe
    p_oe_func_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_oe_o[g] |-> (pad_func_o[3*g +: 3] == 3'd1));
  end
endmodule

bind pinmux_gpio_regs pinmux_gpio_regs_chk #(.NP(NP), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .pad_func_o (pad_func_o),
  .pad_drv_o  (pad_drv_o),
  .pad_pull_o (pad_pull_o),
  .pad_bias_o (pad_bias_o)
);

// File: tb/sim_pinmux_gpio_regs.sv
`timescale 1ns/1ps
module sim_pinmux_gpio_regs;
  localparam int NP = 3;
  localparam int AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NP*32-1:0]  pad_in = '0;
  logic [NP*32-1:0]  pad_out, pad_oe;
  logic [NP*96-1:0]  pad_func;
  logic [NP*64-1:0]  pad_drv, pad_pull;
  logic [NP*4-1:0]   pad_bias;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pinmux_gpio_regs #(.NP(NP), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_func_o(pad_func), .pad_drv_o(pad_drv),
    .pad_pull_o(pad_pull), .pad_bias_o(pad_bias)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 oe after reset", pad_oe[31:0], 32'h0);
    chk("R1 func after reset", pad_func[31:0], 32'h0);
    chk("R1 pull after reset", pad_pull[31:0], 32'h0);
    bus_rd(12'h010, d);
    chk("R1 data reads input level 0", d, 32'h0);
  endtask

  task automatic t_func();
    logic [31:0] d;
    bus_wr(12'h000, 32'hFFFF_FFFF);
    bus_rd(12'h000, d);
    chk("R2 func word nibble bit3 zero", d, 32'h7777_7777);
    chk("R2 pad_func pin0", 32'(pad_func[2:0]), 32'd7);
    bus_wr(12'h00C, 32'h0000_0010);
    chk("R2 pad_func pin25", 32'(pad_func[75 +: 3]), 32'd1);
    chk("R3 oe pin25 only", pad_oe[31:0], 32'h0200_0000);
  endtask

  task automatic t_out();
    bus_wr(12'h010, 32'h0200_0001);
    chk("R3 pad_out follows data reg", pad_out[31:0], 32'h0200_0001);
    chk("R3 oe unaffected by data", pad_oe[31:0], 32'h0200_0000);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    bus_wr(12'h000, 32'h0);
    @(negedge clk);
    pad_in[31:0] = 32'h0000_00F0;
    repeat (3) @(negedge clk);
    bus_rd(12'h010, d);
    chk("R4 mixed in/out read", d, 32'h0200_00F0);
    pad_in[31:0] = 32'h1200_000F;
    repeat (3) @(negedge clk);
    bus_rd(12'h010, d);
    chk("R4 output pin ignores pad", d, 32'h1200_000F);
  endtask

  task automatic t_drive();
    logic [31:0] d;
    // level 30 -> code 2 on pin 20
    bus_wr(12'h018, 32'(2) << 8);
    chk("R5 pad_drv pin20", 32'(pad_drv[40 +: 2]), 32'd2);
    bus_rd(12'h018, d);
    chk("R5 upper drive word", d, 32'h0000_0200);
    bus_rd(12'h014, d);
    chk("R5 lower drive word untouched", d, 32'h0);
  endtask

  task automatic t_pull();
    logic [31:0] d;
    bus_wr(12'h01C, 32'h0000_0009);
    chk("R6 pin0 pull-up", 32'(pad_pull[1:0]), 32'd1);
    chk("R6 pin1 pull-down", 32'(pad_pull[3:2]), 32'd2);
    bus_wr(12'h020, 32'hFFFF_FFFF);
    bus_rd(12'h020, d);
    chk("R6 upper pull word", d, 32'hFFFF_FFFF);
    chk("R6 pad_pull pins16-31", pad_pull[63:32], 32'hFFFF_FFFF);
  endtask

  task automatic t_group();
    logic [31:0] d;
    bus_wr(12'h304, 32'hFFFF_FFFF);
    bus_rd(12'h304, d);
    chk("R7 bias upper bits zero", d, 32'h0000_000F);
    chk("R7 bias port1 / port0", 32'(pad_bias[7:0]), 32'h0000_00F0);
  endtask

  task automatic t_stride();
    logic [31:0] d;
    bus_wr(12'h024, 32'h1111_1111);
    chk("R8 port1 oe pins 32-39", 32'(pad_oe[39:32]), 32'h0000_00FF);
    bus_rd(12'h000, d);
    chk("R8 port0 func untouched", d, 32'h0);
    bus_wr(12'h058, 32'hA5A5_A5A5);
    chk("R8 port2 data", pad_out[95:64], 32'hA5A5_A5A5);
    chk("R8 port0 data untouched", pad_out[31:0], 32'h0200_0001);
    bus_wr(12'h068, 32'h0000_0003);
    chk("R8 port2 pin16 pull", 32'(pad_pull[161:160]), 32'd3);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [NP*96-1:0] f0;
    logic [NP*64-1:0] p0, dr0;
    logic [NP*32-1:0] o0;
    logic [NP*4-1:0]  b0;
    f0 = pad_func; p0 = pad_pull; dr0 = pad_drv; o0 = pad_out; b0 = pad_bias;
    bus_wr(12'h06C, 32'hFFFF_FFFF);
    bus_wr(12'h30C, 32'hFFFF_FFFF);
    bus_wr(12'h026, 32'hFFFF_FFFF);
    bus_wr(12'h200, 32'hFFFF_FFFF);
    n_tests++;
    if (pad_func !== f0 || pad_pull !== p0 || pad_drv !== dr0 || pad_out !== o0 || pad_bias !== b0) begin
      n_fail++;
      $display("FAIL R9 unmapped write changed a field: func %h pull %h expected unchanged",
               pad_func[31:0], pad_pull[31:0]);
    end
    bus_rd(12'h06C, d);
    chk("R9 read past last port", d, 32'h0);
    bus_rd(12'h30C, d);
    chk("R9 read missing bias word", d, 32'h0);
    bus_rd(12'h026, d);
    chk("R9 misaligned read", d, 32'h0);
  endtask

  task automatic t_rd_hold();
    logic [31:0] d;
    bus_rd(12'h018, d);
    chk("R10 read latency", d, 32'h0000_0200);
    repeat (4) @(negedge clk);
    chk("R10 hold over idle", rdata, 32'h0000_0200);
    bus_wr(12'h014, 32'h5555_5555);
    chk("R10 hold over write", rdata, 32'h0000_0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_func();
    t_out();
    t_readback();
    t_drive();
    t_pull();
    t_group();
    t_stride();
    t_unmapped();
    t_rd_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule